// File: doc/BRIEF.md
# Omega Multistage Switching Network

This block connects N request lanes to N delivery lanes through log2 N ranks of 2x2 exchange switches. Ahead of every rank the lanes are rewired by a perfect shuffle: each lane index is rotated left by one bit. Every lane carries a valid flag, a destination index and a payload. Each switch is steered only by the destination bits of the packets that reach it, and rank k looks at one destination bit, taken from the most significant end first.

There is exactly one path from each input to each output, so some sets of requests contend for the same internal link. When the two packets at a switch want the same side, the packet on the upper switch input goes on and the lower one is dropped. The input that sent the dropped packet is flagged as blocked. The network itself is combinational. A parameter adds one register stage at the outputs. Each delivery lane reports a valid flag, the payload and the index of the input it came from.

A requester uses the per-input blocked flags to learn which of its packets did not get through in that cycle. Retrying them is the requester's job.

Top module: `omega_net`

## Requirements
- R1: With OUT_REG=1, the cycle after reset is asserted, every out_valid bit and every blocked bit reads 0.
- R2: A single valid packet from input i to destination d appears on output d, with its payload and with out_src equal to i. No input is flagged blocked.
- R3: Rank k is steered by destination bit (log2 N - 1 - k). A 0 takes the upper switch output and a 1 takes the lower one. When both packets at a switch want the same output, the upper switch input wins. For N=8, a packet from input 0 to 0 and one from input 4 to 1 meet at the first switch: input 0 is delivered and blocked[4]=1.
- R4: An input whose valid bit is 0 is never delivered, never flagged blocked and never blocks another packet.
- R5: Every valid input is either delivered to exactly one output or flagged blocked, never both. A blocked packet appears on no output.
- R6: With OUT_REG=1, the outputs show the routing of the inputs presented one clock earlier, and they hold until the next rising edge.
- R7: For an arbitrary set of requests, the delivered and blocked inputs match the single-path model. The model traces each packet link by link through the ranks and gives every clash to the packet on the upper switch input.
- R8: The identity permutation and every cyclic shift (input i to (i+c) mod N) route with no input blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| in_valid | input | N | Per-input request flag |
| in_dest | input | N*log2 N | Destination index of each input; input i uses bits [i*A +: A] |
| in_data | input | N*W | Payload of each input; input i uses bits [i*W +: W] |
| out_valid | output | N | A packet is delivered on this output |
| out_data | output | N*W | Delivered payload, W bits per output |
| out_src | output | N*log2 N | Index of the input that sent the delivered packet |
| blocked | output | N | Per-input flag: this input's valid packet lost a clash |

## Verification
Lone packets over every input and destination pair show that the tag steering and the shuffle wiring reach the right output. They cannot expose priority faults, because nothing clashes. The identity and cyclic-shift permutations must pass with no blocking, so any stray conflict detection shows up. A hand-built clash between inputs 0 and 4 shows which side wins. A batch of invalid lanes with clashing tags checks that idle lanes stay out of arbitration. Pseudo-random full permutations, checked against a link-tracing model, catch faults in later ranks and in the blocked-flag bookkeeping. Holding the inputs across a clock edge and sampling before the next edge confirms the one-cycle output latency.

// File: rtl/omega_pkg.sv
package omega_pkg;

    // Widest lane index supported (N up to 32)
    localparam int unsigned ADDR_MAX = 5;

    // Routing header that travels with every lane through the ranks
    typedef struct packed {
        logic                valid;
        logic [ADDR_MAX-1:0] dest;
        logic [ADDR_MAX-1:0] src;
    } hdr_t;

    // Perfect shuffle: rotate an lg-bit lane index left by one position
    function automatic int unsigned rotl_idx(input int unsigned idx, input int unsigned lg);
        int unsigned mask;
        mask = (32'd1 << lg) - 32'd1;
        return ((idx << 1) | (idx >> (lg - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch
    import omega_pkg::*;
#(
    parameter int W   = 8,
    parameter int SEL = 0
) (
    input  hdr_t                a_hdr,
    input  logic [W-1:0]        a_dat,
    input  hdr_t                b_hdr,
    input  logic [W-1:0]        b_dat,
    output hdr_t                u_hdr,
    output logic [W-1:0]        u_dat,
    output hdr_t                l_hdr,
    output logic [W-1:0]        l_dat,
    output logic                drop,
    output logic [ADDR_MAX-1:0] drop_src
);

    logic a_side;
    logic b_side;
    logic clash;

    assign a_side   = a_hdr.dest[SEL];
    assign b_side   = b_hdr.dest[SEL];
    assign clash    = a_hdr.valid && b_hdr.valid && (a_side == b_side);
    assign drop     = clash;
    assign drop_src = b_hdr.src;

    always_comb begin
        u_hdr = '0;
        u_dat = '0;
        l_hdr = '0;
        l_dat = '0;
        // upper input is served first
        if (a_hdr.valid) begin
            if (a_side) begin
                l_hdr = a_hdr;
                l_dat = a_dat;
            end else begin
                u_hdr = a_hdr;
                u_dat = a_dat;
            end
        end
        // lower input only when it does not collide
        if (b_hdr.valid && !clash) begin
            if (b_side) begin
                l_hdr = b_hdr;
                l_dat = b_dat;
            end else begin
                u_hdr = b_hdr;
                u_dat = b_dat;
            end
        end
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 8,
    parameter int K = 0
) (
    input  hdr_t         in_hdr  [N],
    input  logic [W-1:0] in_dat  [N],
    output hdr_t         out_hdr [N],
    output logic [W-1:0] out_dat [N],
    output logic [N-1:0] drop_vec
);

    localparam int LG   = $clog2(N);
    localparam int HALF = N / 2;
    localparam int SEL  = LG - 1 - K;

    hdr_t                sh_hdr [N];
    logic [W-1:0]        sh_dat [N];
    logic                sw_drop [HALF];
    logic [ADDR_MAX-1:0] sw_src  [HALF];

    // shuffle wiring ahead of the rank
    for (genvar i = 0; i < N; i++) begin : g_shuf
        localparam int unsigned DST = rotl_idx(i, LG);
        assign sh_hdr[DST] = in_hdr[i];
        assign sh_dat[DST] = in_dat[i];
    end

    for (genvar j = 0; j < HALF; j++) begin : g_sw
        omega_switch #(.W(W), .SEL(SEL)) u_sw (
            .a_hdr   (sh_hdr[2*j]),
            .a_dat   (sh_dat[2*j]),
            .b_hdr   (sh_hdr[2*j+1]),
            .b_dat   (sh_dat[2*j+1]),
            .u_hdr   (out_hdr[2*j]),
            .u_dat   (out_dat[2*j]),
            .l_hdr   (out_hdr[2*j+1]),
            .l_dat   (out_dat[2*j+1]),
            .drop    (sw_drop[j]),
            .drop_src(sw_src[j])
        );
    end

    // translate dropped packets into per-source flags
    always_comb begin
        drop_vec = '0;
        for (int j = 0; j < HALF; j++) begin
            if (sw_drop[j]) drop_vec[sw_src[j][LG-1:0]] = 1'b1;
        end
    end

endmodule

// File: rtl/omega_net.sv
module omega_net
    import omega_pkg::*;
#(
    parameter int N       = 8,
    parameter int W       = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int A      = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   in_valid,
    input  logic [N*A-1:0] in_dest,
    input  logic [N*W-1:0] in_data,
    output logic [N-1:0]   out_valid,
    output logic [N*W-1:0] out_data,
    output logic [N*A-1:0] out_src,
    output logic [N-1:0]   blocked
);

    localparam int LG = A;

    hdr_t         ln_hdr [LG+1][N];
    logic [W-1:0] ln_dat [LG+1][N];
    logic [N-1:0] drop_st [LG];

    logic [N-1:0]   valid_c;
    logic [N*W-1:0] data_c;
    logic [N*A-1:0] src_c;
    logic [N-1:0]   block_c;

    // lane headers entering the first rank
    for (genvar i = 0; i < N; i++) begin : g_in
        hdr_t h;
        always_comb begin
            h          = '0;
            h.valid    = in_valid[i];
            h.dest[A-1:0] = in_dest[i*A +: A];
            h.src      = ADDR_MAX'(i);
        end
        assign ln_hdr[0][i] = h;
        assign ln_dat[0][i] = in_data[i*W +: W];
    end

    for (genvar k = 0; k < LG; k++) begin : g_rank
        omega_stage #(.N(N), .W(W), .K(k)) u_rank (
            .in_hdr  (ln_hdr[k]),
            .in_dat  (ln_dat[k]),
            .out_hdr (ln_hdr[k+1]),
            .out_dat (ln_dat[k+1]),
            .drop_vec(drop_st[k])
        );
    end

    always_comb begin
        block_c = '0;
        for (int k = 0; k < LG; k++) block_c = block_c | drop_st[k];
        for (int o = 0; o < N; o++) begin
            valid_c[o]         = ln_hdr[LG][o].valid;
            data_c[o*W +: W]   = ln_dat[LG][o];
            src_c[o*A +: A]    = ln_hdr[LG][o].src[A-1:0];
        end
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= '0;
                out_data  <= '0;
                out_src   <= '0;
                blocked   <= '0;
            end else begin
                out_valid <= valid_c;
                out_data  <= data_c;
                out_src   <= src_c;
                blocked   <= block_c;
            end
        end
    end else begin : g_comb
        assign out_valid = valid_c;
        assign out_data  = data_c;
        assign out_src   = src_c;
        assign blocked   = block_c;
    end

endmodule

// File: rtl/omega_chk.sv
module omega_chk #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1,
    localparam int A      = $clog2(N)
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   in_valid,
    input logic [N*A-1:0] in_dest,
    input logic [N-1:0]   out_valid,
    input logic [N*A-1:0] out_src,
    input logic [N-1:0]   blocked
);

    logic           rst_q;
    logic           primed;
    logic [N-1:0]   v_q;
    logic [N*A-1:0] d_q;
    logic [N-1:0]   ref_v;
    logic [N*A-1:0] ref_d;
    logic           live;
    logic [N-1:0]   deliv;
    logic           misroute;

    always_ff @(posedge clk) begin
        rst_q  <= rst;
        primed <= !rst;
        v_q    <= in_valid;
        d_q    <= in_dest;
    end

    assign ref_v = OUT_REG ? v_q : in_valid;
    assign ref_d = OUT_REG ? d_q : in_dest;
    assign live  = OUT_REG ? primed : 1'b1;

    always_comb begin
        deliv    = '0;
        misroute = 1'b0;
        for (int o = 0; o < N; o++) begin
            if (out_valid[o]) begin
                deliv[out_src[o*A +: A]] = 1'b1;
                if (ref_d[out_src[o*A +: A]*A +: A] != A'(o)) misroute = 1'b1;
            end
        end
    end

    // R1: outputs quiet after a reset cycle
    always @(posedge clk) begin
        if (OUT_REG && rst_q === 1'b1) begin
            assert_reset_quiet_R1: assert (out_valid == '0 && blocked == '0);
        end
    end

    assert_lands_at_dest_R2: assert property (@(posedge clk) disable iff (rst || !live)
        !misroute);

    assert_idle_never_blocked_R4: assert property (@(posedge clk) disable iff (rst || !live)
        (blocked & ~ref_v) == '0);

    assert_idle_never_delivered_R4: assert property (@(posedge clk) disable iff (rst || !live)
        (deliv & ~ref_v) == '0);

    assert_block_or_deliver_R5: assert property (@(posedge clk) disable iff (rst || !live)
        ((blocked | deliv) == ref_v) && ((blocked & deliv) == '0));

    assert_single_copy_R5: assert property (@(posedge clk) disable iff (rst || !live)
        $countones(out_valid) == $countones(deliv));

endmodule

bind omega_net omega_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_dest  (in_dest),
    .out_valid(out_valid),
    .out_src  (out_src),
    .blocked  (blocked)
);

// File: tb/tb_omega_net.sv
module tb_omega_net;

    localparam int N  = 8;
    localparam int W  = 8;
    localparam int A  = 3;

    logic           clk = 1'b0;
    logic           rst;
    logic [N-1:0]   in_valid;
    logic [N*A-1:0] in_dest;
    logic [N*W-1:0] in_data;
    logic [N-1:0]   out_valid;
    logic [N*W-1:0] out_data;
    logic [N*A-1:0] out_src;
    logic [N-1:0]   blocked;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    // stimulus view
    logic [N-1:0] sv;
    int           sd [N];
    logic [W-1:0] sp [N];

    // expectations
    logic [N-1:0] ev;
    logic [N-1:0] eb;
    int           es [N];
    logic [W-1:0] ep [N];

    always #4 clk = ~clk;

    omega_net dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .out_src(out_src), .blocked(blocked)
    );

    always_comb begin
        in_valid = sv;
        for (int i = 0; i < N; i++) begin
            in_dest[i*A +: A] = A'(sd[i]);
            in_data[i*W +: W] = sp[i];
        end
    end

    // link-tracing model of the single-path network
    task automatic model();
        int  link [N];
        int  pre  [N];
        bit  alive [N];
        ev = '0;
        eb = '0;
        for (int i = 0; i < N; i++) begin
            alive[i] = sv[i];
            link[i]  = i;
            es[i]    = 0;
            ep[i]    = '0;
        end
        for (int k = 0; k < A; k++) begin
            for (int i = 0; i < N; i++) begin
                pre[i]  = ((link[i] << 1) | (link[i] >> (A-1))) & (N-1);
                link[i] = (pre[i] & ~1) | ((sd[i] >> (A-1-k)) & 1);
            end
            for (int i = 0; i < N; i++) begin
                for (int j = i + 1; j < N; j++) begin
                    if (alive[i] && alive[j] && link[i] == link[j]) begin
                        if (pre[i] % 2 == 1) begin
                            alive[i] = 0; eb[i] = 1'b1;
                        end else begin
                            alive[j] = 0; eb[j] = 1'b1;
                        end
                    end
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            if (alive[i]) begin
                ev[link[i]] = 1'b1;
                es[link[i]] = i;
                ep[link[i]] = sp[i];
            end
        end
    endtask

    // compare outputs to the current expectation
    task automatic compare(input string tag);
        bit bad = 0;
        nchk++;
        if (out_valid !== ev || blocked !== eb) bad = 1;
        for (int o = 0; o < N; o++) begin
            if (ev[o] && (out_src[o*A +: A] !== A'(es[o]) || out_data[o*W +: W] !== ep[o])) bad = 1;
        end
        if (bad) begin
            nfail++;
            $display("FAIL %s: out_valid=%b exp %b blocked=%b exp %b src=%h data=%h",
                     tag, out_valid, ev, blocked, eb, out_src, out_data);
        end
    endtask

    // drive at a falling edge, check after the next rising edge
    task automatic apply(input string tag);
        @(negedge clk);
        model();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic clear_in();
        sv = '0;
        for (int i = 0; i < N; i++) begin
            sd[i] = 0;
            sp[i] = '0;
        end
    endtask

    task automatic t_reset();
        clear_in();
        sv = '1;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ev = '0; eb = '0;
        compare("R1 reset state");
        rst = 1'b0;
    endtask

    task automatic t_single();
        for (int i = 0; i < N; i++) begin
            for (int d = 0; d < N; d++) begin
                clear_in();
                sv[i] = 1'b1;
                sd[i] = d;
                sp[i] = W'(i * 29 + d * 7 + 3);
                apply("R2 lone packet");
            end
        end
    endtask

    task automatic t_perm();
        for (int c = 0; c < N; c++) begin
            clear_in();
            sv = '1;
            for (int i = 0; i < N; i++) begin
                sd[i] = (i + c) % N;
                sp[i] = W'(8'hA0 + i + c);
            end
            apply("R8 shift permutation");
            nchk++;
            if (blocked !== '0 || out_valid !== '1) begin
                nfail++;
                $display("FAIL R8: shift %0d blocked=%b exp 00000000 out_valid=%b exp 11111111",
                         c, blocked, out_valid);
            end
        end
    endtask

    task automatic t_priority();
        clear_in();
        sv[0] = 1'b1; sd[0] = 0; sp[0] = 8'h11;
        sv[4] = 1'b1; sd[4] = 1; sp[4] = 8'h44;
        @(negedge clk);
        @(negedge clk);
        ev = 8'b0000_0001; eb = 8'b0001_0000;
        es[0] = 0; ep[0] = 8'h11;
        compare("R3 upper input wins");
    endtask

    task automatic t_invalid();
        clear_in();
        for (int i = 0; i < N; i++) sp[i] = W'(8'h55 + i);
        apply("R4 all idle with clashing tags");
        sv = 8'b0101_0101;
        for (int i = 0; i < N; i++) sd[i] = i % 2;
        apply("R4 idle lanes among clashes");
        nchk++;
        if ((blocked & 8'b1010_1010) !== '0) begin
            nfail++;
            $display("FAIL R4: idle blocked=%b exp 00000000", blocked & 8'b1010_1010);
        end
    endtask

    task automatic t_latency();
        clear_in();
        sv = '1;
        for (int i = 0; i < N; i++) begin
            sd[i] = i;
            sp[i] = W'(i + 8'h30);
        end
        apply("R6 first vector");
        for (int i = 0; i < N; i++) begin
            sd[i] = (N - 1) - i;
            sp[i] = W'(i + 8'h70);
        end
        #2;
        nchk++;
        if (out_data[W-1:0] !== 8'h30 || out_src[A-1:0] !== 3'd0) begin
            nfail++;
            $display("FAIL R6: early change data=%h exp 30 src=%0d exp 0",
                     out_data[W-1:0], out_src[A-1:0]);
        end
        model();
        @(negedge clk);
        compare("R6 second vector after one edge");
    endtask

    task automatic t_random();
        logic [15:0] lfsr = 16'hACE1;
        int tmp;
        int r;
        for (int n = 0; n < 200; n++) begin
            clear_in();
            for (int i = 0; i < N; i++) sd[i] = i;
            for (int i = N - 1; i > 0; i--) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                r = int'(lfsr) % (i + 1);
                tmp = sd[i]; sd[i] = sd[r]; sd[r] = tmp;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sv = (n % 3 == 0) ? lfsr[N-1:0] : '1;
            for (int i = 0; i < N; i++) sp[i] = W'(n * 13 + i * 5);
            apply("R7 random request set");
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: run hung, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst = 1'b1;
        t_reset();
        t_single();
        t_perm();
        t_priority();
        t_invalid();
        t_latency();
        t_random();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule